// File: doc/BRIEF.md
# PASID-Scoped IOTLB Invalidation Engine

This block sits between an invalidation queue and a small translation cache. It takes one queued invalidation descriptor at a time over a valid/ready input. It checks the descriptor's format against the queue's descriptor-width mode. If the descriptor is well formed, it removes every cached translation that belongs to the named domain and PASID, or only those inside a naturally aligned page range. The cache holds 16 fully associative entries. Each entry is tagged with a domain ID, a PASID and a virtual page number. The cache is filled in round-robin order and answers lookups in the same cycle they are asked.

Back-pressure rules are as follows. A descriptor is taken on a clock edge where `dsc_valid` and `dsc_ready` are both high. `dsc_ready` stays low from the edge that accepts a descriptor until that descriptor's status cycle is over, so the source must hold its descriptor until `dsc_ready` returns. Lookups and fills share one ready signal, `tlb_ready`, which is low for the whole flush sweep. A fill offered while `tlb_ready` is low is not written. A lookup asked while `tlb_ready` is low reports a miss and must be asked again. Completion is reported on two plain one-cycle status pulses: `inv_done` for a finished flush and `inv_err` for a rejected descriptor.

Top module: `pinv_engine`

## Requirements
- R1: A descriptor is accepted on a rising edge with `dsc_valid` and `dsc_ready` both high. `dsc_ready` is high only when the engine is idle, and it is low in every cycle from the accepting edge through the cycle that carries `inv_done` or `inv_err`.
- R2: When `qmode_wide` is 0 (16-byte descriptor queue), every accepted descriptor is rejected as invalid, because this descriptor needs the 32-byte format. Words 2 and 3 do not matter in that case.
- R3: In wide mode (`qmode_wide`=1) a descriptor is invalid if any of these hold: the type field `dsc_w0[3:0]` is not 6; the granularity field `dsc_w0[5:4]` is 0 or 1; `dsc_w0` has a 1 under mask 0xfff000000000f1c0; `dsc_w1` has a 1 under mask 0xf80; `dsc_w2` or `dsc_w3` is nonzero. Bits `dsc_w0[11:9]` and `dsc_w1[6]` are free and never cause an error.
- R4: For an invalid descriptor, `inv_err` is high for exactly the one cycle after the accepting edge. In that case `inv_done` stays low and no cache entry changes.
- R5: Granularity 2 (`dsc_w0[5:4]`=2) invalidates every valid entry whose domain ID equals `dsc_w0[31:16]` and whose PASID equals `dsc_w0[51:32]`, whatever its page number.
- R6: Granularity 3 additionally requires page equality. The page is `dsc_w1[63:12]` and the mask order is `dsc_w1[5:0]`. An entry's page matches when it equals the descriptor page after both have their low mask-order bits ignored. An order of 52 or more matches every page.
- R7: A valid descriptor starts a sweep of 16 cycles, one entry per cycle in index order. `inv_done` is high only in the 17th cycle after the accepting edge, and for one cycle only.
- R8: A lookup hits when some valid entry has equal domain ID, PASID and page number. The lowest-index such entry supplies `lk_ppn`. During the sweep `tlb_ready` is low and `lk_hit` is low.
- R9: A fill is written when `fill_valid` and `tlb_ready` are both high. It goes to the slot under a round-robin pointer that starts at 0 after reset, advances by one per fill and wraps from 15 to 0, so the 17th fill replaces the first.
- R10: After reset all entries are invalid, `dsc_ready` and `tlb_ready` are high, and `inv_done` and `inv_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qmode_wide | input | 1 | Queue descriptor width: 1 = 32-byte, 0 = 16-byte |
| dsc_valid | input | 1 | Descriptor offered |
| dsc_ready | output | 1 | Engine can take a descriptor |
| dsc_w0 | input | 64 | Descriptor word 0 (type, granularity, domain, PASID) |
| dsc_w1 | input | 64 | Descriptor word 1 (page, mask order) |
| dsc_w2 | input | 64 | Descriptor word 2 (must be zero) |
| dsc_w3 | input | 64 | Descriptor word 3 (must be zero) |
| tlb_ready | output | 1 | Lookup and fill port available |
| lk_valid | input | 1 | Lookup request |
| lk_did | input | 16 | Lookup domain ID |
| lk_pasid | input | 20 | Lookup PASID |
| lk_vpn | input | 52 | Lookup page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 40 | Translated page of the hitting entry |
| fill_valid | input | 1 | Fill request |
| fill_did | input | 16 | Fill domain ID |
| fill_pasid | input | 20 | Fill PASID |
| fill_vpn | input | 52 | Fill page number |
| fill_ppn | input | 40 | Fill translated page |
| inv_done | output | 1 | One-cycle pulse: flush finished |
| inv_err | output | 1 | One-cycle pulse: descriptor rejected |

## Verification
The cache is filled from small pools of domain IDs, PASIDs and page numbers. This makes many entries share one or two tag fields. A PASID flush therefore has to tell a full tag match apart from a partial one, for example the same domain with a different PASID. Page-selective flushes run with mask orders 0, 4 and 63, which separates an exact page match from an aligned range match and from a match on every page. Each format error is injected on its own into an otherwise valid descriptor, and free bits are also set, so a too-wide or too-narrow reserved check shows up. After every descriptor, each tag is looked up again to confirm that exactly the expected entries survived. Fills past sixteen exercise the round-robin wrap.

// File: rtl/pinv_pkg.sv
package pinv_pkg;
  localparam int DID_W   = 16;
  localparam int PASID_W = 20;
  localparam int VPN_W   = 52;
  localparam int AM_W    = 6;

  localparam logic [3:0]  DSC_TYPE_PIOTLB = 4'd6;
  localparam logic [63:0] W0_RSV_MASK     = 64'hfff0_0000_0000_f1c0;
  localparam logic [63:0] W1_RSV_MASK     = 64'h0000_0000_0000_0f80;

  typedef struct packed {
    logic [DID_W-1:0]   did;
    logic [PASID_W-1:0] pasid;
    logic [VPN_W-1:0]   vpn;
    logic [AM_W-1:0]    am;
    logic               page_sel;
  } inv_req_t;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RUN  = 2'd1,
    SW_DONE = 2'd2,
    SW_FAIL = 2'd3
  } sw_state_e;

  function automatic logic page_eq(input logic [VPN_W-1:0] a,
                                   input logic [VPN_W-1:0] b,
                                   input logic [AM_W-1:0]  am);
    logic [VPN_W-1:0] keep;
    keep = (int'(am) >= VPN_W) ? '0 : ({VPN_W{1'b1}} << am);
    return ((a ^ b) & keep) == '0;
  endfunction
endpackage

// File: rtl/pinv_decode.sv
module pinv_decode
  import pinv_pkg::*;
(
  input  logic        wide,
  input  logic [63:0] w0,
  input  logic [63:0] w1,
  input  logic [63:0] w2,
  input  logic [63:0] w3,
  output logic        bad,
  output inv_req_t    req
);
  logic type_bad, gran_bad, rsv_bad, width_bad;
  logic unused_free_bits;

  // 16-byte queue cannot carry this 32-byte descriptor
  assign width_bad = !wide;
  assign type_bad  = (w0[3:0] != DSC_TYPE_PIOTLB);
  // granularity 0 and 1 are reserved; only 2 and 3 are legal
  assign gran_bad  = (w0[5] == 1'b0);
  assign rsv_bad   = (|(w0 & W0_RSV_MASK)) || (|(w1 & W1_RSV_MASK)) ||
                     (|w2) || (|w3);
  assign bad       = width_bad || type_bad || gran_bad || rsv_bad;

  assign req.did      = w0[31:16];
  assign req.pasid    = w0[51:32];
  assign req.vpn      = w1[63:12];
  assign req.am       = w1[5:0];
  assign req.page_sel = w0[4];

  assign unused_free_bits = ^{w0[11:9], w1[6]};
endmodule

// File: rtl/pinv_tlb.sv
module pinv_tlb
  import pinv_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 40,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DID_W-1:0]   lk_did,
  input  logic [PASID_W-1:0] lk_pasid,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn,
  input  logic               fill_en,
  input  logic [DID_W-1:0]   fill_did,
  input  logic [PASID_W-1:0] fill_pasid,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic               sweep_en,
  input  logic [IDX_W-1:0]   sweep_idx,
  input  inv_req_t           crit
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [DID_W-1:0]   e_did   [ENTRIES];
  logic [PASID_W-1:0] e_pasid [ENTRIES];
  logic [VPN_W-1:0]   e_vpn   [ENTRIES];
  logic [PPN_W-1:0]   e_ppn   [ENTRIES];
  logic [ENTRIES-1:0] tag_hit;
  logic [ENTRIES-1:0] inv_hit;
  logic [IDX_W-1:0]   rr_ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign tag_hit[g] = vld[g] && (e_did[g] == lk_did) &&
                        (e_pasid[g] == lk_pasid) && (e_vpn[g] == lk_vpn);
    assign inv_hit[g] = vld[g] && (e_did[g] == crit.did) &&
                        (e_pasid[g] == crit.pasid) &&
                        (!crit.page_sel || page_eq(e_vpn[g], crit.vpn, crit.am));
  end

  // lowest index wins
  always_comb begin
    hit     = |tag_hit;
    hit_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_hit[i]) hit_ppn = e_ppn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rr_ptr <= '0;
    end else if (fill_en) begin
      vld[rr_ptr] <= 1'b1;
      rr_ptr      <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end else if (sweep_en && inv_hit[sweep_idx]) begin
      vld[sweep_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_did[rr_ptr]   <= fill_did;
      e_pasid[rr_ptr] <= fill_pasid;
      e_vpn[rr_ptr]   <= fill_vpn;
      e_ppn[rr_ptr]   <= fill_ppn;
    end
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && inv_hit[sweep_idx]) |=> !vld[$past(sweep_idx)]); // R5
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld[$past(rr_ptr)]); // R9
  AST_NO_FILL_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && sweep_en)); // R8
endmodule

// File: rtl/pinv_sweep.sv
module pinv_sweep
  import pinv_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             start_bad,
  input  inv_req_t         req_in,
  output logic             idle,
  output logic             sweep_en,
  output logic [IDX_W-1:0] sweep_idx,
  output inv_req_t         crit,
  output logic             done,
  output logic             err
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  sw_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SW_IDLE;
      sweep_idx <= '0;
      crit      <= '0;
    end else begin
      case (state)
        SW_IDLE: begin
          if (start_ok) begin
            state     <= SW_RUN;
            sweep_idx <= '0;
            crit      <= req_in;
          end else if (start_bad) begin
            state <= SW_FAIL;
          end
        end
        SW_RUN: begin
          if (sweep_idx == LAST) state <= SW_DONE;
          else                   sweep_idx <= sweep_idx + 1'b1;
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  assign idle     = (state == SW_IDLE);
  assign sweep_en = (state == SW_RUN);
  assign done     = (state == SW_DONE);
  assign err      = (state == SW_FAIL);

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(sweep_en) && ($past(sweep_idx) == LAST))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/pinv_engine.sv
module pinv_engine
  import pinv_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qmode_wide,
  input  logic               dsc_valid,
  output logic               dsc_ready,
  input  logic [63:0]        dsc_w0,
  input  logic [63:0]        dsc_w1,
  input  logic [63:0]        dsc_w2,
  input  logic [63:0]        dsc_w3,
  output logic               tlb_ready,
  input  logic               lk_valid,
  input  logic [DID_W-1:0]   lk_did,
  input  logic [PASID_W-1:0] lk_pasid,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic               fill_valid,
  input  logic [DID_W-1:0]   fill_did,
  input  logic [PASID_W-1:0] fill_pasid,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  output logic               inv_done,
  output logic               inv_err
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             dsc_fire;
  logic             dsc_bad;
  inv_req_t         dsc_req;
  inv_req_t         crit;
  logic             eng_idle;
  logic             sweep_en;
  logic [IDX_W-1:0] sweep_idx;
  logic             raw_hit;
  logic [PPN_W-1:0] raw_ppn;
  logic             fill_en;

  assign dsc_ready = eng_idle;
  assign dsc_fire  = dsc_valid && dsc_ready;
  assign tlb_ready = !sweep_en;
  assign fill_en   = fill_valid && tlb_ready;
  assign lk_hit    = lk_valid && tlb_ready && raw_hit;
  assign lk_ppn    = raw_ppn;

  pinv_decode u_decode (
    .wide (qmode_wide),
    .w0   (dsc_w0),
    .w1   (dsc_w1),
    .w2   (dsc_w2),
    .w3   (dsc_w3),
    .bad  (dsc_bad),
    .req  (dsc_req)
  );

  pinv_sweep #(.ENTRIES(ENTRIES)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (dsc_fire && !dsc_bad),
    .start_bad (dsc_fire && dsc_bad),
    .req_in    (dsc_req),
    .idle      (eng_idle),
    .sweep_en  (sweep_en),
    .sweep_idx (sweep_idx),
    .crit      (crit),
    .done      (inv_done),
    .err       (inv_err)
  );

  pinv_tlb #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_did     (lk_did),
    .lk_pasid   (lk_pasid),
    .lk_vpn     (lk_vpn),
    .hit        (raw_hit),
    .hit_ppn    (raw_ppn),
    .fill_en    (fill_en),
    .fill_did   (fill_did),
    .fill_pasid (fill_pasid),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .sweep_en   (sweep_en),
    .sweep_idx  (sweep_idx),
    .crit       (crit)
  );

  AST_NARROW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_fire && !qmode_wide) |=> inv_err); // R2
  AST_ERR_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_err && inv_done)); // R4
  AST_BUSY_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_fire |=> !dsc_ready); // R1
endmodule

// File: tb/pinv_engine_bench.sv
module pinv_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qmode_wide = 1'b1;
  logic        dsc_valid = 1'b0;
  logic        dsc_ready;
  logic [63:0] dsc_w0 = '0, dsc_w1 = '0, dsc_w2 = '0, dsc_w3 = '0;
  logic        tlb_ready;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_did = '0;
  logic [19:0] lk_pasid = '0;
  logic [51:0] lk_vpn = '0;
  logic        lk_hit;
  logic [39:0] lk_ppn;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_did = '0;
  logic [19:0] fill_pasid = '0;
  logic [51:0] fill_vpn = '0;
  logic [39:0] fill_ppn = '0;
  logic        inv_done, inv_err;

  int checks = 0;
  int errors = 0;

  // model
  bit          m_vld   [16];
  logic [15:0] m_did   [16];
  logic [19:0] m_pasid [16];
  logic [51:0] m_vpn   [16];
  logic [39:0] m_ppn   [16];
  int          m_rr = 0;

  always #10 clk = ~clk;

  pinv_engine u_pinv_engine (
    .clk(clk), .rst_n(rst_n), .qmode_wide(qmode_wide),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_w0(dsc_w0), .dsc_w1(dsc_w1), .dsc_w2(dsc_w2), .dsc_w3(dsc_w3),
    .tlb_ready(tlb_ready),
    .lk_valid(lk_valid), .lk_did(lk_did), .lk_pasid(lk_pasid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_did(fill_did), .fill_pasid(fill_pasid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_done(inv_done), .inv_err(inv_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_w0(input logic [15:0] did, input logic [19:0] pasid,
                                        input logic [1:0] gran, input logic [3:0] typ);
    return {12'h0, pasid, did, 4'h0, 3'b000, 3'b000, gran, typ};
  endfunction

  function automatic logic [63:0] mk_w1(input logic [51:0] vpn, input logic [5:0] am, input bit ih);
    return {vpn, 5'b0, ih, am};
  endfunction

  function automatic bit exp_bad(input logic [63:0] w0, w1, w2, w3, input bit wide);
    if (!wide) return 1'b1;
    if (w0[3:0] != 4'd6) return 1'b1;
    if (w0[5:4] < 2'd2) return 1'b1;
    if ((w0 & 64'hfff000000000f1c0) != 0) return 1'b1;
    if ((w1 & 64'h0000000000000f80) != 0) return 1'b1;
    if (w2 != 0 || w3 != 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit pg_match(input logic [51:0] a, b, input int am);
    if (am >= 52) return 1'b1;
    return ((a ^ b) >> am) == 0;
  endfunction

  task automatic m_flush(input logic [63:0] w0, w1);
    for (int i = 0; i < 16; i++) begin
      if (m_vld[i] && m_did[i] == w0[31:16] && m_pasid[i] == w0[51:32] &&
          (w0[5:4] == 2'd2 || pg_match(m_vpn[i], w1[63:12], int'(w1[5:0]))))
        m_vld[i] = 1'b0;
    end
  endtask

  task automatic lookup(input string tag, input logic [15:0] d, input logic [19:0] p,
                        input logic [51:0] v);
    bit eh = 1'b0;
    logic [39:0] ep = '0;
    for (int i = 15; i >= 0; i--)
      if (m_vld[i] && m_did[i] == d && m_pasid[i] == p && m_vpn[i] == v) begin
        eh = 1'b1; ep = m_ppn[i];
      end
    @(negedge clk);
    lk_valid = 1'b1; lk_did = d; lk_pasid = p; lk_vpn = v;
    #2;
    chk(tag, {63'd0, lk_hit}, {63'd0, eh});
    if (eh) chk({tag, " ppn"}, {24'd0, lk_ppn}, {24'd0, ep});
    lk_valid = 1'b0;
  endtask

  task automatic verify_all(input string tag);
    for (int i = 0; i < 16; i++) lookup(tag, m_did[i], m_pasid[i], m_vpn[i]);
  endtask

  task automatic fill(input logic [15:0] d, input logic [19:0] p, input logic [51:0] v,
                      input logic [39:0] pp);
    @(negedge clk);
    fill_valid = 1'b1; fill_did = d; fill_pasid = p; fill_vpn = v; fill_ppn = pp;
    @(negedge clk);
    fill_valid = 1'b0;
    m_vld[m_rr] = 1'b1; m_did[m_rr] = d; m_pasid[m_rr] = p; m_vpn[m_rr] = v; m_ppn[m_rr] = pp;
    m_rr = (m_rr + 1) % 16;
  endtask

  task automatic do_inv(input string tag, input logic [63:0] w0, w1, w2, w3, input bit wide);
    bit bad;
    int k;
    bad = exp_bad(w0, w1, w2, w3, wide);
    @(negedge clk);
    qmode_wide = wide; dsc_w0 = w0; dsc_w1 = w1; dsc_w2 = w2; dsc_w3 = w3;
    dsc_valid = 1'b1;
    chk({tag, " R1 ready when idle"}, {63'd0, dsc_ready}, 64'd1);
    @(negedge clk);
    dsc_valid = 1'b0;
    chk({tag, " R1 ready low after accept"}, {63'd0, dsc_ready}, 64'd0);
    if (bad) begin
      chk({tag, " R4 err pulse"}, {63'd0, inv_err}, 64'd1);
      chk({tag, " R4 no done"}, {63'd0, inv_done}, 64'd0);
      @(negedge clk);
      chk({tag, " R4 err one cycle"}, {63'd0, inv_err}, 64'd0);
    end else begin
      chk({tag, " R4 no err"}, {63'd0, inv_err}, 64'd0);
      chk({tag, " R8 tlb stalled"}, {63'd0, tlb_ready}, 64'd0);
      lk_valid = 1'b1; lk_did = m_did[0]; lk_pasid = m_pasid[0]; lk_vpn = m_vpn[0];
      #2;
      chk({tag, " R8 no hit in sweep"}, {63'd0, lk_hit}, 64'd0);
      lk_valid = 1'b0;
      k = 1;
      while (!inv_done && k < 40) begin
        @(negedge clk);
        k++;
      end
      chk({tag, " R7 done cycle"}, 64'(k), 64'd17);
      chk({tag, " R1 ready low in done"}, {63'd0, dsc_ready}, 64'd0);
      m_flush(w0, w1);
      @(negedge clk);
      chk({tag, " R7 done one cycle"}, {63'd0, inv_done}, 64'd0);
    end
    chk({tag, " R1 ready back"}, {63'd0, dsc_ready}, 64'd1);
    qmode_wide = 1'b1;
    verify_all({tag, " R5 R6 survivors"});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h1d5e_a7c3);
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 0; m_did[i] = 16'hffff; m_pasid[i] = 20'hfffff; m_vpn[i] = '0; m_ppn[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 dsc_ready", {63'd0, dsc_ready}, 64'd1);
    chk("R10 tlb_ready", {63'd0, tlb_ready}, 64'd1);
    chk("R10 done low", {63'd0, inv_done}, 64'd0);
    chk("R10 err low", {63'd0, inv_err}, 64'd0);
    lookup("R10 empty miss", 16'hffff, 20'hfffff, 52'd0);

    // R9 round robin wrap
    for (int i = 0; i < 17; i++) fill(16'd9, 20'd9, 52'(i + 100), 40'(i + 1));
    lookup("R9 first fill replaced", 16'd9, 20'd9, 52'd100);
    lookup("R9 seventeenth fill present", 16'd9, 20'd9, 52'd116);
    lookup("R9 second fill present", 16'd9, 20'd9, 52'd101);

    // R8 lowest index wins on duplicate tags
    fill(16'd7, 20'd7, 52'd7, 40'haaa);
    fill(16'd7, 20'd7, 52'd7, 40'hbbb);
    lookup("R8 duplicate lowest index", 16'd7, 20'd7, 52'd7);

    // populate for flush tests
    for (int i = 0; i < 16; i++)
      fill(16'(1 + i % 2), 20'(5 + (i / 2) % 2), 52'(i * 3), 40'(i + 200));

    // R2 narrow mode rejects an otherwise valid descriptor
    do_inv("R2 narrow", mk_w0(16'd1, 20'd5, 2'd2, 4'd6), '0, '0, '0, 1'b0);
    do_inv("R2 narrow junk hi", mk_w0(16'd1, 20'd5, 2'd2, 4'd6), '0, 64'h55, 64'h1, 1'b0);
    // R3 individual format errors
    do_inv("R3 w0 bit7", mk_w0(16'd1, 20'd5, 2'd2, 4'd6) | 64'h80, '0, '0, '0, 1'b1);
    do_inv("R3 w0 bit60", mk_w0(16'd1, 20'd5, 2'd2, 4'd6) | (64'd1 << 60), '0, '0, '0, 1'b1);
    do_inv("R3 w0 bit13", mk_w0(16'd1, 20'd5, 2'd2, 4'd6) | 64'h2000, '0, '0, '0, 1'b1);
    do_inv("R3 w1 bit9", mk_w0(16'd1, 20'd5, 2'd3, 4'd6), 64'h200, '0, '0, 1'b1);
    do_inv("R3 w2 nonzero", mk_w0(16'd1, 20'd5, 2'd2, 4'd6), '0, 64'h1, '0, 1'b1);
    do_inv("R3 w3 nonzero", mk_w0(16'd1, 20'd5, 2'd2, 4'd6), '0, '0, 64'h8000_0000_0000_0000, 1'b1);
    do_inv("R3 gran0", mk_w0(16'd1, 20'd5, 2'd0, 4'd6), '0, '0, '0, 1'b1);
    do_inv("R3 gran1", mk_w0(16'd1, 20'd5, 2'd1, 4'd6), '0, '0, '0, 1'b1);
    do_inv("R3 wrong type", mk_w0(16'd1, 20'd5, 2'd2, 4'd4), '0, '0, '0, 1'b1);
    // R6 page selective with free bits set, order 0 then 4
    do_inv("R6 exact page", mk_w0(16'd1, 20'd5, 2'd3, 4'd6) | 64'he00,
           mk_w1(52'd0, 6'd0, 1'b1), '0, '0, 1'b1);
    do_inv("R6 order4", mk_w0(16'd2, 20'd6, 2'd3, 4'd6), mk_w1(52'd5, 6'd4, 1'b0), '0, '0, 1'b1);
    // R5 PASID-wide
    do_inv("R5 pasid flush", mk_w0(16'd2, 20'd5, 2'd2, 4'd6), '0, '0, '0, 1'b1);
    do_inv("R6 order63", mk_w0(16'd1, 20'd6, 2'd3, 4'd6), mk_w1(52'd999, 6'd63, 1'b0), '0, '0, 1'b1);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 5) begin
        fill(16'($urandom % 3), 20'($urandom % 2 + 5), {20'($urandom % 2), 32'($urandom % 48)},
             40'($urandom));
      end else if (op < 8) begin
        lookup("R8 random lookup", 16'($urandom % 3), 20'($urandom % 2 + 5),
               {20'($urandom % 2), 32'($urandom % 48)});
      end else begin
        logic [63:0] w0, w1, w2, w3;
        bit wide;
        int bad_sel;
        w0 = mk_w0(16'($urandom % 3), 20'($urandom % 2 + 5), 2'($urandom % 2 + 2), 4'd6);
        w1 = mk_w1({20'($urandom % 2), 32'($urandom % 48)}, 6'($urandom % 8), 1'($urandom % 2));
        w2 = '0; w3 = '0; wide = 1'b1;
        bad_sel = int'($urandom % 8);
        case (bad_sel)
          0: w0 = w0 | (64'd1 << (52 + $urandom % 12));
          1: w1 = w1 | (64'd1 << (7 + $urandom % 5));
          2: w2 = 64'($urandom) | 64'd1;
          3: wide = 1'b0;
          default: ;
        endcase
        do_inv("R5 R6 random inv", w0, w1, w2, w3, wide);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule